// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit with Hi/Lo Result Pair

This block performs one 32-bit integer multiplication or division at a time and leaves the result in a pair of dedicated result registers, Hi and Lo. A command is issued with a one-cycle start pulse together with a two-bit operation code and two operands. The unit then iterates once per clock cycle over the 32 operand bits. Multiplication uses shift-and-add. Division uses restoring shift-and-subtract. Both operations run on operand magnitudes, and a final cycle corrects the signs and writes Hi and Lo together.

A multiply leaves the upper half of the 64-bit product in Hi and the lower half in Lo. A divide leaves the quotient in Lo and the remainder in Hi. Neither operation traps or flags overflow. Software-style moves from Hi and from Lo use a combinational read port whose select input chooses the register. A busy flag covers the whole operation so that the surrounding pipeline can stall. Division by zero does not trap, and its Hi/Lo contents are not defined.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, busy and done are 0 and both Hi and Lo read as zero.
- R2: Operation code 2'b01 (unsigned multiply) leaves the unsigned 64-bit product of the operands in {Hi, Lo}: Hi holds bits 63..32 and Lo holds bits 31..0.
- R3: Operation code 2'b00 (signed multiply) treats both operands as two's complement. It leaves the sign-extended 64-bit product in {Hi, Lo}, for example (-8) x (-7) = 56 and (-1) x (-1) = 1.
- R4: Operation code 2'b11 (unsigned divide) leaves the unsigned quotient in Lo and the remainder in Hi, for any nonzero divisor.
- R5: Operation code 2'b10 (signed divide) divides the magnitudes and truncates toward zero. The quotient is negative exactly when the operand signs differ and the magnitude quotient is nonzero.
- R6: For a signed divide, the remainder takes the sign of the dividend and its magnitude is smaller than the divisor magnitude. For an unsigned divide, the remainder is smaller than the divisor.
- R7: If start is sampled high while the unit is idle at clock edge k, busy is high after edges k through k+32. At edge k+33 busy falls, Hi and Lo are written, and done is high for exactly that one cycle.
- R8: A start pulse while busy is high is ignored. The running operation keeps its timing, and Hi/Lo receive only its result.
- R9: The read port returns Hi when the select input is 1 and Lo when it is 0, combinationally.
- R10: Hi and Lo change only at a completion edge. Between completions they hold their values, whatever happens on the command inputs.
- R11: No operation flags or traps overflow. A signed divide of 0x80000000 by 0xFFFFFFFF wraps to quotient 0x80000000 with remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe, accepted only while idle |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa_i | input | 32 | Multiplier or dividend |
| opb_i | input | 32 | Multiplicand or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse; Hi/Lo valid |
| rd_hi_i | input | 1 | Read select: 1 = Hi, 0 = Lo |
| rd_data_o | output | 32 | Selected result register |

## Verification
The multiplier is exercised with the following operand pairs:
- Two small negatives, which separates sign-extended from zero-extended products.
- All-ones operands under both signed and unsigned codes, where the two interpretations give very different Hi words from the same bits.
- The most negative value squared, which reaches the top of the product range.

The divider is exercised with:
- All four sign combinations of seven by two, which pin down the quotient sign and that the remainder follows the dividend.
- A dividend smaller than the divisor.
- The most negative value divided by minus one, which checks the wrap without an overflow flag.
- Pseudo-random operand pairs.

A second start pulse injected in the middle of a run shows whether the running operation is disturbed.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    MD_MUL_S = 2'b00,
    MD_MUL_U = 2'b01,
    MD_DIV_S = 2'b10,
    MD_DIV_U = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } md_state_e;

endpackage

// File: rtl/md_sign_prep.sv
module md_sign_prep
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic [WIDTH-1:0] mag_a_o,
  output logic [WIDTH-1:0] mag_b_o,
  output logic             is_div_o,
  output logic             neg_lo_o,
  output logic             neg_hi_o
);

  logic is_signed;
  logic sgn_a;
  logic sgn_b;

  always_comb begin
    is_signed = (op_i == MD_MUL_S) || (op_i == MD_DIV_S);
    is_div_o  = (op_i == MD_DIV_S) || (op_i == MD_DIV_U);
    sgn_a     = is_signed & opa_i[WIDTH-1];
    sgn_b     = is_signed & opb_i[WIDTH-1];
    mag_a_o   = sgn_a ? (~opa_i + 1'b1) : opa_i;
    mag_b_o   = sgn_b ? (~opb_i + 1'b1) : opb_i;
    // mul: both flags negate the whole product; div: lo = quotient, hi = remainder
    neg_lo_o  = sgn_a ^ sgn_b;
    neg_hi_o  = is_div_o ? sgn_a : (sgn_a ^ sgn_b);
  end

endmodule

// File: rtl/md_iter_core.sv
module md_iter_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             is_div_i,
  input  logic [WIDTH-1:0] mag_a_i,
  input  logic [WIDTH-1:0] mag_b_i,
  output logic [WIDTH-1:0] hi_raw_o,
  output logic [WIDTH-1:0] lo_raw_o
);

  logic [WIDTH-1:0] acc_hi_q, acc_hi_d;
  logic [WIDTH-1:0] acc_lo_q, acc_lo_d;
  logic [WIDTH-1:0] opnd_q,   opnd_d;
  logic [WIDTH:0]   sum;
  logic [WIDTH:0]   shl;
  logic [WIDTH:0]   diff;
  logic             reg_en;

  always_comb begin
    acc_hi_d = acc_hi_q;
    acc_lo_d = acc_lo_q;
    opnd_d   = opnd_q;
    sum      = {1'b0, acc_hi_q} + {1'b0, opnd_q};
    shl      = {acc_hi_q, acc_lo_q[WIDTH-1]};
    diff     = shl - {1'b0, opnd_q};
    reg_en   = load_i | step_i;
    if (load_i) begin
      acc_hi_d = '0;
      acc_lo_d = mag_a_i;
      opnd_d   = mag_b_i;
    end else if (step_i) begin
      if (is_div_i) begin
        if (!diff[WIDTH]) begin
          acc_hi_d = diff[WIDTH-1:0];
          acc_lo_d = {acc_lo_q[WIDTH-2:0], 1'b1};
        end else begin
          acc_hi_d = shl[WIDTH-1:0];
          acc_lo_d = {acc_lo_q[WIDTH-2:0], 1'b0};
        end
      end else if (acc_lo_q[0]) begin
        {acc_hi_d, acc_lo_d} = {sum, acc_lo_q[WIDTH-1:1]};
      end else begin
        {acc_hi_d, acc_lo_d} = {1'b0, acc_hi_q, acc_lo_q[WIDTH-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi_q <= '0;
      acc_lo_q <= '0;
      opnd_q   <= '0;
    end else if (reg_en) begin
      acc_hi_q <= acc_hi_d;
      acc_lo_q <= acc_lo_d;
      opnd_q   <= opnd_d;
    end
  end

  assign hi_raw_o = acc_hi_q;
  assign lo_raw_o = acc_lo_q;

  // partial remainder stays below the divisor through every restoring step
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && is_div_i && (opnd_q != '0)) |-> (acc_hi_q < opnd_q)); // R6

endmodule

// File: rtl/md_result_fix.sv
module md_result_fix #(
  parameter int WIDTH = 32
) (
  input  logic             is_div_i,
  input  logic             neg_lo_i,
  input  logic             neg_hi_i,
  input  logic [WIDTH-1:0] hi_raw_i,
  input  logic [WIDTH-1:0] lo_raw_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);

  localparam int DW = 2 * WIDTH;

  logic [DW-1:0] prod_neg;

  always_comb begin
    prod_neg = ~{hi_raw_i, lo_raw_i} + 1'b1;
    if (is_div_i) begin
      lo_o = neg_lo_i ? (~lo_raw_i + 1'b1) : lo_raw_i;
      hi_o = neg_hi_i ? (~hi_raw_i + 1'b1) : hi_raw_i;
    end else if (neg_lo_i) begin
      {hi_o, lo_o} = prod_neg;
    end else begin
      {hi_o, lo_o} = {hi_raw_i, lo_raw_i};
    end
  end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic             busy_o,
  output logic             done_o,
  input  logic             rd_hi_i,
  output logic [WIDTH-1:0] rd_data_o
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] ITERS = CW'(WIDTH);
  localparam logic [CW-1:0] LAST  = CW'(1);

  md_state_e        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             div_q, neg_lo_q, neg_hi_q;
  logic             done_q, done_d;
  logic [WIDTH-1:0] hi_q, lo_q;

  logic             load;
  logic             step;
  logic             hilo_en;
  logic [WIDTH-1:0] mag_a, mag_b;
  logic             pre_div, pre_neg_lo, pre_neg_hi;
  logic [WIDTH-1:0] hi_raw, lo_raw;
  logic [WIDTH-1:0] hi_fix, lo_fix;

  md_sign_prep #(.WIDTH(WIDTH)) u_prep (
    .op_i     (op_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .mag_a_o  (mag_a),
    .mag_b_o  (mag_b),
    .is_div_o (pre_div),
    .neg_lo_o (pre_neg_lo),
    .neg_hi_o (pre_neg_hi)
  );

  md_iter_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (step),
    .is_div_i (div_q),
    .mag_a_i  (mag_a),
    .mag_b_i  (mag_b),
    .hi_raw_o (hi_raw),
    .lo_raw_o (lo_raw)
  );

  md_result_fix #(.WIDTH(WIDTH)) u_fix (
    .is_div_i (div_q),
    .neg_lo_i (neg_lo_q),
    .neg_hi_i (neg_hi_q),
    .hi_raw_i (hi_raw),
    .lo_raw_i (lo_raw),
    .hi_o     (hi_fix),
    .lo_o     (lo_fix)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    step    = 1'b0;
    hilo_en = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load    = 1'b1;
          cnt_d   = ITERS;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step  = 1'b1;
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == LAST) begin
          state_d = ST_FIX;
        end
      end
      ST_FIX: begin
        hilo_en = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // operation flags, captured on command acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= 1'b0;
      neg_lo_q <= 1'b0;
      neg_hi_q <= 1'b0;
    end else if (load) begin
      div_q    <= pre_div;
      neg_lo_q <= pre_neg_lo;
      neg_hi_q <= pre_neg_hi;
    end
  end

  // Hi/Lo result pair, written together on completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (hilo_en) begin
      hi_q <= hi_fix;
      lo_q <= lo_fix;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign rd_data_o = rd_hi_i ? hi_q : lo_q;

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R7

  AST_RUN_NOT_RESTARTED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q > LAST) |=> (state_q == ST_RUN && cnt_q == $past(cnt_q) - 1'b1)); // R8

  AST_HILO_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(hi_q) && $stable(lo_q)) |-> done_o); // R10

endmodule

// File: tb/sim_muldiv_hilo.sv
`timescale 1ns/100ps
module sim_muldiv_hilo;

  localparam int W = 32;

  typedef struct {
    logic [W-1:0] hi;
    logic [W-1:0] lo;
    string        tag;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [1:0]   op_i;
  logic [W-1:0] opa_i;
  logic [W-1:0] opb_i;
  logic         busy_o;
  logic         done_o;
  logic         rd_hi_i;
  logic [W-1:0] rd_data_o;

  int   n_checks;
  int   n_errors;
  exp_t sb_q[$];
  bit   finished;

  muldiv_hilo #(.WIDTH(W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .op_i      (op_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rd_hi_i   (rd_hi_i),
    .rd_data_o (rd_data_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  function automatic exp_t model(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    exp_t e;
    logic signed [63:0] sa, sb, sq, sr;
    logic [63:0] p;
    e.tag = tag;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    case (op)
      2'b00: begin p = sa * sb; e.hi = p[63:32]; e.lo = p[31:0]; end
      2'b01: begin p = {32'b0, a} * {32'b0, b}; e.hi = p[63:32]; e.lo = p[31:0]; end
      2'b10: begin sq = sa / sb; sr = sa % sb; e.hi = sr[31:0]; e.lo = sq[31:0]; end
      default: begin e.lo = a / b; e.hi = a % b; end
    endcase
    return e;
  endfunction

  // driver: issues one command, checks R7 timing, optionally injects a stray start (R8)
  task automatic run_op(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit glitch, input string tag);
    sb_q.push_back(model(op, a, b, tag));
    @(negedge clk);
    start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i <= W; i++) begin
      if (i != 0) @(negedge clk);
      if (glitch && i == 5) begin
        start_i = 1'b1; op_i = ~op; opa_i = ~a; opb_i = 32'h3;
      end
      if (glitch && i == 6) start_i = 1'b0;
      check(busy_o && !done_o, "R7 busy window", {62'b0, busy_o, done_o}, 64'h2);
    end
    @(negedge clk);
    check(done_o && !busy_o, "R7 done pulse", {62'b0, busy_o, done_o}, 64'h1);
    @(negedge clk);
    check(!done_o, "R7 done one cycle", {63'b0, done_o}, 64'h0);
  endtask

  // monitor: pops scoreboard on each completion and reads Hi/Lo through the port
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done_o) begin
        logic [W-1:0] hi_rd, lo_rd;
        rd_hi_i = 1'b1; #0.5; hi_rd = rd_data_o;
        rd_hi_i = 1'b0; #0.5; lo_rd = rd_data_o;
        if (sb_q.size() == 0) begin
          check(1'b0, "R8 unexpected completion", {hi_rd, lo_rd}, 64'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(hi_rd == e.hi, {e.tag, " Hi (R9)"}, {32'b0, hi_rd}, {32'b0, e.hi});
          check(lo_rd == e.lo, {e.tag, " Lo (R9)"}, {32'b0, lo_rd}, {32'b0, e.lo});
        end
      end
    end
  end

  // watchdog
  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    check(1'b0, "watchdog expired", 64'h0, 64'h0);
    finish_sim();
  end

  initial begin
    logic [W-1:0] lfsr;
    logic [W-1:0] hold_hi, hold_lo;
    n_checks = 0; n_errors = 0; finished = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; op_i = 2'b00; opa_i = '0; opb_i = '0; rd_hi_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!busy_o && !done_o, "R1 flags", {62'b0, busy_o, done_o}, 64'h0);
    rd_hi_i = 1'b1; #0.5;
    check(rd_data_o == '0, "R1 Hi", {32'b0, rd_data_o}, 64'h0);
    rd_hi_i = 1'b0; #0.5;
    check(rd_data_o == '0, "R1 Lo", {32'b0, rd_data_o}, 64'h0);

    run_op(2'b00, -32'sd8, -32'sd7, 1'b0, "R3 mult -8*-7");
    run_op(2'b00, 32'd3, -32'sd5, 1'b0, "R3 mult 3*-5");
    run_op(2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R3 mult -1*-1");
    run_op(2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R2 multu max*max");
    run_op(2'b00, 32'h80000000, 32'h80000000, 1'b0, "R3 mult min*min");
    run_op(2'b01, 32'h0, 32'h12345678, 1'b0, "R2 multu zero");
    run_op(2'b01, 32'h0001_0003, 32'h0000_F00D, 1'b0, "R2 multu small");
    run_op(2'b11, 32'd100, 32'd7, 1'b0, "R4 divu 100/7");
    run_op(2'b11, 32'hFFFFFFFF, 32'd1, 1'b0, "R4 divu max/1");
    run_op(2'b11, 32'd5, 32'hFFFFFFF0, 1'b0, "R6 divu small/large");
    run_op(2'b10, -32'sd7, 32'd2, 1'b0, "R5 R6 div -7/2");
    run_op(2'b10, 32'd7, -32'sd2, 1'b0, "R5 R6 div 7/-2");
    run_op(2'b10, -32'sd7, -32'sd2, 1'b0, "R5 R6 div -7/-2");
    run_op(2'b10, 32'd7, 32'd2, 1'b0, "R5 div 7/2");
    run_op(2'b10, 32'h80000000, 32'hFFFFFFFF, 1'b0, "R11 div min/-1");
    run_op(2'b01, 32'hDEADBEEF, 32'h00C0FFEE, 1'b1, "R8 multu with stray start");
    run_op(2'b10, -32'sd1000, 32'd33, 1'b1, "R8 div with stray start");

    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 12; k++) begin
      logic [W-1:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = (k[0]) ? (lfsr >> (k % 24)) : lfsr;
      if (b == '0) b = 32'd3;
      run_op(k[1:0], a, b, 1'b0, (k[1]) ? "R4 R5 R6 random div" : "R2 R3 random mul");
    end

    // R10: Hi/Lo hold while idle, even with command inputs toggling (no start)
    rd_hi_i = 1'b1; #0.5; hold_hi = rd_data_o;
    rd_hi_i = 1'b0; #0.5; hold_lo = rd_data_o;
    @(negedge clk);
    op_i = 2'b01; opa_i = 32'h5555AAAA; opb_i = 32'h77;
    repeat (5) @(negedge clk);
    rd_hi_i = 1'b1; #0.5;
    check(rd_data_o == hold_hi, "R10 Hi held", {32'b0, rd_data_o}, {32'b0, hold_hi});
    rd_hi_i = 1'b0; #0.5;
    check(rd_data_o == hold_lo, "R10 Lo held", {32'b0, rd_data_o}, {32'b0, hold_lo});
    check(sb_q.size() == 0, "R8 scoreboard drained", 64'(sb_q.size()), 64'h0);

    repeat (2) @(negedge clk);
    finish_sim();
  end

endmodule